// File: doc/BRIEF.md
# Memory-Mapped 16-Bit Output Port

This block is a write-only output port on a processor bus that has an 8-bit data bus and a 10-bit address bus. The port takes up two neighbouring byte addresses. The lower of the two is even and is set through a 7-bit configuration input, so the port can sit at any even base from 0x00 to 0xFF. Address bit 0 chooses the byte lane. Bits 7..1 must equal the configuration value, and bits 9..8 must both be zero.

A write to the even address does not reach the output. It is held in a staging byte. A write to the odd address moves its data and the staged byte into the 16-bit output register in one clock edge, so a consumer never sees a word that is half old and half new. A one-cycle flag tells the consumer that a fresh word is present. An output-enable input either passes the stored word or forces the output to zero.

The byte count is a parameter. Every lane except the last is staged, and the last lane commits the whole word.

Top module: `wport_top`

## Requirements
- R1: After a cycle with `rst` high, the staging byte and the output word are zero and `fresh` is low, so a lone odd-address write of value V then shows `{V, 8'h00}`.
- R2: A write hits the port only when `wr_n` is low, `bus_addr[9:8]` is 0 and `bus_addr[7:1]` equals `base_cfg`. `bus_addr[0]` = 0 selects the low byte and 1 selects the high byte.
- R3: An address with a non-zero `bus_addr[9:8]` never hits the port, even when its bits 7..1 match `base_cfg`.
- R4: A hit at the even address loads only the staging byte. `port_q` does not change.
- R5: A hit at the odd address sets the output word to `{bus_data, staged byte}` on that same clock edge. Both bytes change together.
- R6: `fresh` is high for exactly the one cycle that follows each odd-address hit edge, and low otherwise. Back-to-back odd hits keep it high for consecutive cycles.
- R7: A write with `wr_n` high, or to a non-matching address, leaves the staging byte, the output word and `fresh` as they were.
- R8: While `out_en` is low, `port_q` reads zero and the stored word is kept. `port_q` shows the word again once `out_en` returns high.
- R9: The staging byte survives a commit, so a second odd-address hit with no even hit between them reuses the earlier low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 10 | Processor address bus |
| bus_data | input | 8 | Processor write data |
| wr_n | input | 1 | Active-low write strobe |
| base_cfg | input | 7 | Even base address, bits 7..1 |
| out_en | input | 1 | High passes the output word, low forces zero |
| port_q | output | 16 | Output word |
| fresh | output | 1 | One-cycle pulse after each word update |

## Verification
Two functions can meet in the same cycle: the commit of a new word and the gating of that word by `out_en`. A second case is a commit that lands in the cycle right after a `fresh` pulse caused by the previous commit. Random transactions are issued back to back with no idle cycles, and `out_en` is drawn at random for each one. This makes odd-address hits fall with the enable low and follow one another directly. For every transaction a bench model predicts the gated word and the flag, and both are compared one cycle later. A later enabled read then shows that a word committed while gated was still stored.

// File: rtl/wport_pkg.sv
package wport_pkg;
  localparam int unsigned DEF_DATA_W = 8;
  localparam int unsigned DEF_ADDR_W = 10;
  localparam int unsigned DEF_SPAN_W = 8;
  localparam int unsigned DEF_NBYTES = 2;

  function automatic bit is_pow2(input int unsigned v);
    return (v != 0) && ((v & (v - 1)) == 0);
  endfunction
endpackage

// File: rtl/wport_decode.sv
module wport_decode #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned SPAN_W = 8,
  parameter int unsigned NBYTES = 2,
  localparam int unsigned LANE_W = $clog2(NBYTES),
  localparam int unsigned BASE_W = SPAN_W - LANE_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_n,
  input  logic [BASE_W-1:0] base_cfg,
  output logic [NBYTES-1:0] lane_we
);
  logic upper_clear;
  logic hit;

  generate
    if (ADDR_W > SPAN_W) begin : g_upper
      assign upper_clear = (addr[ADDR_W-1:SPAN_W] == '0);
    end else begin : g_noupper
      assign upper_clear = 1'b1;
    end
  endgenerate

  assign hit = !wr_n && upper_clear && (addr[SPAN_W-1:LANE_W] == base_cfg);

  for (genvar l = 0; l < NBYTES; l++) begin : g_lane
    assign lane_we[l] = hit && (addr[LANE_W-1:0] == LANE_W'(l));
  end

  always_comb begin
    assert_onehot_R2: assert ($onehot0(lane_we));
  end

  generate
    if (ADDR_W > SPAN_W) begin : g_upper_chk
      always_comb begin
        if (addr[ADDR_W-1:SPAN_W] != '0)
          assert_upper_block_R3: assert (lane_we == '0);
      end
    end
  endgenerate
endmodule

// File: rtl/wport_stage.sv
module wport_stage #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NBYTES = 2,
  localparam int unsigned NSTG = NBYTES - 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NSTG-1:0]          stg_we,
  input  logic [DATA_W-1:0]        din,
  output logic [NSTG*DATA_W-1:0]   stage_q
);
  for (genvar s = 0; s < NSTG; s++) begin : g_stg
    always_ff @(posedge clk) begin
      if (rst) stage_q[s*DATA_W +: DATA_W] <= '0;
      else if (stg_we[s]) stage_q[s*DATA_W +: DATA_W] <= din;
    end
  end

  assert_stage_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (stg_we == '0) |=> $stable(stage_q));
  assert_stage_load_R4: assert property (@(posedge clk) disable iff (rst)
    stg_we[0] |=> (stage_q[DATA_W-1:0] == $past(din)));
endmodule

// File: rtl/wport_commit.sv
module wport_commit #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NBYTES = 2,
  localparam int unsigned WORD_W = DATA_W * NBYTES,
  localparam int unsigned STG_W  = DATA_W * (NBYTES - 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  logic [DATA_W-1:0] din,
  input  logic [STG_W-1:0]  stage_q,
  output logic [WORD_W-1:0] word_q,
  output logic              fresh
);
  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      fresh  <= 1'b0;
    end else begin
      fresh <= commit;
      if (commit) word_q <= {din, stage_q};
    end
  end

  assert_fresh_rise_R6: assert property (@(posedge clk) disable iff (rst)
    commit |=> fresh);
  assert_fresh_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    !commit |=> !fresh);
  assert_word_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(word_q));
  assert_word_atomic_R5: assert property (@(posedge clk) disable iff (rst)
    commit |=> (word_q[WORD_W-1 -: DATA_W] == $past(din)));
endmodule

// File: rtl/wport_top.sv
module wport_top #(
  parameter int unsigned DATA_W = wport_pkg::DEF_DATA_W,
  parameter int unsigned ADDR_W = wport_pkg::DEF_ADDR_W,
  parameter int unsigned SPAN_W = wport_pkg::DEF_SPAN_W,
  parameter int unsigned NBYTES = wport_pkg::DEF_NBYTES,
  localparam int unsigned LANE_W = $clog2(NBYTES),
  localparam int unsigned BASE_W = SPAN_W - LANE_W,
  localparam int unsigned WORD_W = DATA_W * NBYTES,
  localparam int unsigned NSTG   = NBYTES - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              wr_n,
  input  logic [BASE_W-1:0] base_cfg,
  input  logic              out_en,
  output logic [WORD_W-1:0] port_q,
  output logic              fresh
);
  logic [NBYTES-1:0]      lane_we;
  logic [NSTG*DATA_W-1:0] stage_q;
  logic [WORD_W-1:0]      word_q;

  initial begin
    if (NBYTES < 2 || !wport_pkg::is_pow2(NBYTES)) $error("NBYTES must be a power of two >= 2");
    if (SPAN_W > ADDR_W || SPAN_W <= LANE_W) $error("SPAN_W out of range");
  end

  wport_decode #(.ADDR_W(ADDR_W), .SPAN_W(SPAN_W), .NBYTES(NBYTES)) u_dec (
    .addr(bus_addr), .wr_n(wr_n), .base_cfg(base_cfg), .lane_we(lane_we)
  );

  wport_stage #(.DATA_W(DATA_W), .NBYTES(NBYTES)) u_stg (
    .clk(clk), .rst(rst), .stg_we(lane_we[NSTG-1:0]), .din(bus_data), .stage_q(stage_q)
  );

  wport_commit #(.DATA_W(DATA_W), .NBYTES(NBYTES)) u_cmt (
    .clk(clk), .rst(rst), .commit(lane_we[NBYTES-1]), .din(bus_data),
    .stage_q(stage_q), .word_q(word_q), .fresh(fresh)
  );

  assign port_q = out_en ? word_q : '0;

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (word_q == '0 && stage_q == '0 && !fresh));
endmodule

// File: tb/test_wport_top.sv
`timescale 1ns/1ps
module test_wport_top;
  logic clk = 1'b0;
  logic rst;
  logic [9:0] bus_addr;
  logic [7:0] bus_data;
  logic wr_n;
  logic [6:0] base_cfg;
  logic out_en;
  logic [15:0] port_q;
  logic fresh;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0]  m_stg;
  logic [15:0] m_word;
  logic        m_fresh;

  always #2.5 clk = ~clk;

  wport_top i_wport_top (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_data(bus_data), .wr_n(wr_n),
    .base_cfg(base_cfg), .out_en(out_en), .port_q(port_q), .fresh(fresh)
  );

  function automatic logic is_hit(input logic [9:0] a, input logic wn, input logic [6:0] b);
    return !wn && (a[9:8] == 2'b00) && (a[7:1] == b);
  endfunction

  function automatic logic [15:0] gate(input logic oe, input logic [15:0] w);
    return oe ? w : 16'h0000;
  endfunction

  task automatic check(input logic ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Caller stands at a falling edge; drive now, judge at the next falling edge.
  task automatic txn(input logic [9:0] a, input logic [7:0] d, input logic wn, input logic oe);
    string tag;
    logic h;
    h = is_hit(a, wn, base_cfg);
    bus_addr = a; bus_data = d; wr_n = wn; out_en = oe;
    if (h && a[0]) tag = "R5";
    else if (h) tag = "R4";
    else if (!wn && a[9:8] != 0 && a[7:1] == base_cfg) tag = "R3";
    else tag = "R7";
    if (!oe) tag = {tag, "/R8"};
    if (h && !a[0]) m_stg = d;
    if (h && a[0]) m_word = {d, m_stg};
    m_fresh = h && a[0];
    @(negedge clk);
    check(port_q === gate(oe, m_word), tag, port_q, gate(oe, m_word));
    check(fresh === m_fresh, "R6", {15'd0, fresh}, {15'd0, m_fresh});
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [9:0] ra;
    void'($urandom(32'd1234));
    rst = 1'b1; bus_addr = '0; bus_data = '0; wr_n = 1'b1; out_en = 1'b1; base_cfg = 7'h2A;
    m_stg = '0; m_word = '0; m_fresh = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(port_q === 16'h0000, "R1", port_q, 16'h0000);
    check(fresh === 1'b0, "R1", {15'd0, fresh}, 16'h0000);

    // R1: lone odd write after reset exposes zero staged byte
    txn({2'b00, 7'h2A, 1'b1}, 8'hA5, 1'b0, 1'b1);
    check(port_q === 16'hA500, "R1", port_q, 16'hA500);
    // R4 then R5: even stages, odd commits atomically
    txn({2'b00, 7'h2A, 1'b0}, 8'h34, 1'b0, 1'b1);
    txn({2'b00, 7'h2A, 1'b1}, 8'h12, 1'b0, 1'b1);
    check(port_q === 16'h1234, "R5", port_q, 16'h1234);
    // R9: staged byte reused, back-to-back commits keep fresh high (R6)
    txn({2'b00, 7'h2A, 1'b1}, 8'h56, 1'b0, 1'b1);
    check(port_q === 16'h5634, "R9", port_q, 16'h5634);
    // R3: upper bits set, matching lower bits
    txn({2'b01, 7'h2A, 1'b0}, 8'hEE, 1'b0, 1'b1);
    txn({2'b10, 7'h2A, 1'b1}, 8'hEE, 1'b0, 1'b1);
    // R7: strobe high, then wrong base; staging untouched revealed by commit
    txn({2'b00, 7'h2A, 1'b0}, 8'h99, 1'b1, 1'b1);
    txn({2'b00, 7'h2B, 1'b0}, 8'h77, 1'b0, 1'b1);
    txn({2'b00, 7'h2A, 1'b1}, 8'h01, 1'b0, 1'b1);
    check(port_q === 16'h0134, "R7", port_q, 16'h0134);
    // R8: commit while gated, then reveal
    txn({2'b00, 7'h2A, 1'b0}, 8'hCD, 1'b0, 1'b0);
    txn({2'b00, 7'h2A, 1'b1}, 8'hAB, 1'b0, 1'b0);
    txn(10'h3FF, 8'h00, 1'b1, 1'b1);
    check(port_q === 16'hABCD, "R8", port_q, 16'hABCD);
    // R2: other base values, including the two extremes
    base_cfg = 7'h00;
    txn(10'h000, 8'h11, 1'b0, 1'b1);
    txn(10'h001, 8'h22, 1'b0, 1'b1);
    base_cfg = 7'h7F;
    txn(10'h0FE, 8'h33, 1'b0, 1'b1);
    txn(10'h0FF, 8'h44, 1'b0, 1'b1);
    check(port_q === 16'h4433, "R2", port_q, 16'h4433);

    for (int i = 0; i < 2000; i++) begin
      if ($urandom_range(0, 49) == 0) base_cfg = 7'($urandom);
      case ($urandom_range(0, 9))
        0, 1, 2, 3, 4, 5: ra = {2'b00, base_cfg, 1'($urandom)};
        6: ra = {2'($urandom_range(1, 3)), base_cfg, 1'($urandom)};
        default: ra = 10'($urandom);
      endcase
      txn(ra, 8'($urandom), ($urandom_range(0, 4) == 0), ($urandom_range(0, 3) != 0));
    end

    wr_n = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule